// File: doc/BRIEF.md
# Stereo Eight-Times Audio Interpolator

This block raises a stereo stream of 20-bit audio samples to eight times its input rate. Three doubling stages sit in cascade. Each stage inserts a zero between consecutive samples and smooths the result with a symmetric half-band kernel. The first stage uses a 7-tap kernel, and the second and third stages use a short 3-tap kernel. Every product is formed on one shared multiply-accumulate unit that steps through a fixed schedule: the whole left channel is worked through first, then the right. Outputs are 23-bit words meant for a noise-shaping modulator downstream.

The input is a valid/ready stream that carries one left/right pair per beat. The output is a valid/ready stream of eight left/right pairs per accepted input pair. The block takes a new pair only when it is idle and every output of the previous pair has been delivered, so `in_ready` is its only way to push back. On the output side, a low `out_ready` freezes the current output pair for as long as needed, and nothing is lost. With `out_ready` held high, a full frame takes 59 clock cycles, so a clock of 64 times the input rate keeps up.

Top module: `interp8`

## Requirements
- R1: `in_ready` is high only while the block is idle and holds no undelivered output, and it is never high in a cycle where `out_valid` is high. A pair is taken on a clock edge where `in_valid` and `in_ready` are both high.
- R2: Each accepted pair produces exactly eight output pairs, in time order. All eight are delivered before the next pair is accepted.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high on the next cycle, and `out_left` and `out_right` keep their values.
- R4: A two's-complement input sample x enters the first stage as x·8, which places it in the upper 20 bits of the 23-bit word.
- R5: With stage-1 history x[n] (newest) to x[n-3], the stage emits an even output and then an odd output. The even output is round(−16·x[n] + 144·x[n−1] + 144·x[n−2] − 16·x[n−3]). The odd output is round(256·x[n−1]).
- R6: Stages 2 and 3 each take the outputs of the stage before as their input x, one at a time. For every such input the stage emits round(128·x[n] + 128·x[n−1]) first and round(256·x[n]) second.
- R7: round(S) means floor((S + 128) / 256): add 128, then shift right 8 bits arithmetically.
- R8: Every stage result is clamped to the range −4194304 to 4194303 before it is stored or output.
- R9: The left and right channels keep separate filter histories, so a sample on one channel never changes the output of the other.
- R10: With `out_ready` held high, `in_ready` returns high within 64 clock cycles after an acceptance.
- R11: Reset is synchronous and active low. It clears all filter histories to zero, and after it `in_ready` is 1 and `out_valid` is 0.
- R12: When the same input c has been applied for at least four pairs, every output equals 8·c exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 64 times the input sample rate or faster |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_left | input | IN_W (20) | Left input sample, two's complement |
| in_right | input | IN_W (20) | Right input sample, two's complement |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair this cycle |
| out_left | output | OUT_W (23) | Left output sample, two's complement |
| out_right | output | OUT_W (23) | Right output sample, two's complement |

## Verification
The first stimulus is a unit impulse on the left channel only. Its small values exercise the half-way rounding in every stage, and any leak into the right channel shows up as non-zero right outputs. A held constant separates exact unity gain per output phase from gain or offset errors. Full-scale steps force the stage-1 overshoot into the clamp. A full-scale sine and seeded random pairs, sent with a randomly stalled output side, compare every word with a stage-by-stage integer model. This catches errors in the schedule order, the history shifts and the hold rules.

// File: rtl/interp8_pkg.sv
package interp8_pkg;

  localparam int COEF_W   = 10;
  localparam int FRAC     = 8;
  localparam int S1_LEN   = 7;
  localparam int HB_LEN   = 3;
  localparam int S1_HIST  = (S1_LEN + 1) / 2;
  localparam int HB_HIST  = (HB_LEN + 1) / 2;
  localparam int N_JOBS   = 14;
  localparam int N_OUT    = 8;

  typedef enum logic [1:0] {ST_A = 2'd0, ST_B = 2'd1, ST_C = 2'd2} stage_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RUN = 2'd1, PH_DRAIN = 2'd2} phase_e;

  typedef struct packed {
    stage_e stage;
    logic   odd;
  } job_t;

  // Depth-first walk: each result is pushed into the next stage at once,
  // so the next stage must finish both phases before the next push.
  function automatic job_t job_of(logic [3:0] j);
    job_t r;
    case (j)
      4'd0:  r = '{ST_A, 1'b0};
      4'd1:  r = '{ST_B, 1'b0};
      4'd2:  r = '{ST_C, 1'b0};
      4'd3:  r = '{ST_C, 1'b1};
      4'd4:  r = '{ST_B, 1'b1};
      4'd5:  r = '{ST_C, 1'b0};
      4'd6:  r = '{ST_C, 1'b1};
      4'd7:  r = '{ST_A, 1'b1};
      4'd8:  r = '{ST_B, 1'b0};
      4'd9:  r = '{ST_C, 1'b0};
      4'd10: r = '{ST_C, 1'b1};
      4'd11: r = '{ST_B, 1'b1};
      4'd12: r = '{ST_C, 1'b0};
      default: r = '{ST_C, 1'b1};
    endcase
    return r;
  endfunction

  function automatic logic [2:0] taps_of(stage_e s, logic odd);
    if (s == ST_A) return odd ? 3'd3 : 3'd4;
    return odd ? 3'd1 : 3'd2;
  endfunction

  function automatic logic signed [COEF_W-1:0] coef_of(stage_e s, logic [2:0] k);
    if (s == ST_A) begin
      case (k)
        3'd0, 3'd6: return -10'sd16;
        3'd2, 3'd4: return 10'sd144;
        3'd3:       return 10'sd256;
        default:    return 10'sd0;
      endcase
    end
    case (k)
      3'd0, 3'd2: return 10'sd128;
      3'd1:       return 10'sd256;
      default:    return 10'sd0;
    endcase
  endfunction

endpackage

// File: rtl/interp8_mac.sv
module interp8_mac #(
  parameter int SMP_W  = 23,
  parameter int COEF_W = 10,
  parameter int ACC_W  = 36,
  parameter int FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     first,
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [SMP_W-1:0]  sample,
  output logic        [SMP_W-1:0]  result
);

  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
  localparam logic [ACC_W-1:0] MAXV = {{(ACC_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = ~MAXV;

  logic signed [ACC_W-1:0] acc, prod, sum, rnd;

  always_comb begin
    prod = $signed({{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef} *
                   {{(ACC_W-SMP_W){sample[SMP_W-1]}}, sample});
    sum  = (first ? '0 : acc) + prod;
    rnd  = (sum + $signed(HALF)) >>> FRAC;
    if (rnd > $signed(MAXV))      result = MAXV[SMP_W-1:0];
    else if (rnd < $signed(MINV)) result = MINV[SMP_W-1:0];
    else                          result = rnd[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= sum;
  end

endmodule

// File: rtl/interp8_store.sv
module interp8_store
  import interp8_pkg::*;
#(
  parameter int W     = 23,
  parameter int NCH   = 2,
  parameter int H1    = 4,
  parameter int H2    = 2,
  parameter int NOUT  = 8,
  parameter int TAP_W = 2,
  parameter int OIX_W = 3,
  parameter int CH_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [NCH*W-1:0]   load_bus,
  input  logic               wr_en,
  input  stage_e             wr_stage,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [OIX_W-1:0]   wr_idx,
  input  logic [W-1:0]       wr_data,
  input  stage_e             rd_stage,
  input  logic [CH_W-1:0]    rd_ch,
  input  logic [TAP_W-1:0]   rd_tap,
  output logic [W-1:0]       rd_data,
  input  logic [OIX_W-1:0]   out_idx,
  output logic [NCH*W-1:0]   out_bus
);

  localparam int H2_AW = (H2 > 1) ? $clog2(H2) : 1;

  logic [W-1:0] rd_v [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] h1 [H1];
    logic [W-1:0] h2 [H2];
    logic [W-1:0] h3 [H2];
    logic [W-1:0] ob [NOUT];
    logic         hit;

    assign hit = wr_en && (wr_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < H1; i++) h1[i] <= '0;
        for (int i = 0; i < H2; i++) begin
          h2[i] <= '0;
          h3[i] <= '0;
        end
        for (int i = 0; i < NOUT; i++) ob[i] <= '0;
      end else begin
        if (load_en) begin
          h1[0] <= load_bus[c*W +: W];
          for (int i = 1; i < H1; i++) h1[i] <= h1[i-1];
        end
        if (hit) begin
          case (wr_stage)
            ST_A: begin
              h2[0] <= wr_data;
              for (int i = 1; i < H2; i++) h2[i] <= h2[i-1];
            end
            ST_B: begin
              h3[0] <= wr_data;
              for (int i = 1; i < H2; i++) h3[i] <= h3[i-1];
            end
            default: ob[wr_idx] <= wr_data;
          endcase
        end
      end
    end

    always_comb begin
      case (rd_stage)
        ST_A:    rd_v[c] = h1[rd_tap];
        ST_B:    rd_v[c] = h2[rd_tap[H2_AW-1:0]];
        default: rd_v[c] = h3[rd_tap[H2_AW-1:0]];
      endcase
    end

    assign out_bus[c*W +: W] = ob[out_idx];
  end

  assign rd_data = rd_v[rd_ch];

endmodule

// File: rtl/interp8.sv
module interp8 #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_left,
  input  logic [IN_W-1:0]  in_right,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);
  import interp8_pkg::*;

  localparam int NCH   = 2;
  localparam int SCALE = OUT_W - IN_W;
  localparam int ACC_W = OUT_W + COEF_W + 3;
  localparam int TAP_W = $clog2(S1_HIST);
  localparam int JOB_W = $clog2(N_JOBS);
  localparam int OIX_W = $clog2(N_OUT);

  phase_e             state;
  logic               ch;
  logic [JOB_W-1:0]   job;
  logic [TAP_W-1:0]   tap;
  logic [OIX_W-1:0]   ocnt, dcnt;

  job_t                     jb;
  logic [2:0]               ntaps, kidx;
  logic signed [COEF_W-1:0] coef;
  logic                     last_tap, accept, run, wr_en;
  logic [OUT_W-1:0]         smp, res;
  logic [NCH*OUT_W-1:0]     load_bus, out_bus;

  assign jb       = job_of(4'(job));
  assign ntaps    = taps_of(jb.stage, jb.odd);
  assign kidx     = {tap, 1'b0} + {2'b00, jb.odd};
  assign coef     = coef_of(jb.stage, kidx);
  assign last_tap = ({1'b0, tap} == ntaps - 3'd1);

  assign in_ready  = (state == PH_IDLE);
  assign out_valid = (state == PH_DRAIN);
  assign accept    = in_valid && in_ready;
  assign run       = (state == PH_RUN);
  assign wr_en     = run && last_tap;

  assign load_bus  = {in_right, {SCALE{1'b0}}, in_left, {SCALE{1'b0}}};
  assign out_left  = out_bus[OUT_W-1:0];
  assign out_right = out_bus[2*OUT_W-1:OUT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      ch    <= 1'b0;
      job   <= '0;
      tap   <= '0;
      ocnt  <= '0;
      dcnt  <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (accept) begin
            state <= PH_RUN;
            ch    <= 1'b0;
            job   <= '0;
            tap   <= '0;
          end
        end
        PH_RUN: begin
          if (last_tap) begin
            tap <= '0;
            if (jb.stage == ST_C) ocnt <= ocnt + 1'b1;
            if (job == JOB_W'(N_JOBS - 1)) begin
              job <= '0;
              if (ch) begin
                state <= PH_DRAIN;
                dcnt  <= '0;
              end else begin
                ch <= 1'b1;
              end
            end else begin
              job <= job + 1'b1;
            end
          end else begin
            tap <= tap + 1'b1;
          end
        end
        default: begin
          if (out_ready) begin
            dcnt <= dcnt + 1'b1;
            if (dcnt == OIX_W'(N_OUT - 1)) state <= PH_IDLE;
          end
        end
      endcase
    end
  end

  interp8_store #(
    .W(OUT_W), .NCH(NCH), .H1(S1_HIST), .H2(HB_HIST), .NOUT(N_OUT),
    .TAP_W(TAP_W), .OIX_W(OIX_W), .CH_W(1)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (accept),
    .load_bus (load_bus),
    .wr_en    (wr_en),
    .wr_stage (jb.stage),
    .wr_ch    (ch),
    .wr_idx   (ocnt),
    .wr_data  (res),
    .rd_stage (jb.stage),
    .rd_ch    (ch),
    .rd_tap   (tap),
    .rd_data  (smp),
    .out_idx  (dcnt),
    .out_bus  (out_bus)
  );

  interp8_mac #(
    .SMP_W(OUT_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)
  ) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run),
    .first  (tap == '0),
    .coef   (coef),
    .sample ($signed(smp)),
    .result (res)
  );

endmodule

// File: rtl/interp8_chk.sv
module interp8_chk #(
  parameter int OUT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_left,
  input logic [OUT_W-1:0] out_right
);

  logic [3:0] ocount;
  logic       seen;
  logic [6:0] busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocount <= '0;
      seen   <= 1'b0;
      busy   <= '0;
    end else begin
      if (in_valid && in_ready) begin
        ocount <= '0;
        seen   <= 1'b1;
        busy   <= '0;
      end else begin
        if (out_valid && out_ready && ocount != 4'hf) ocount <= ocount + 1'b1;
        if (!in_ready && !(out_valid && !out_ready) && busy != 7'h7f) busy <= busy + 1'b1;
      end
    end
  end

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_eight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && seen) |-> (ocount == 4'd8));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  assert_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (busy < 7'd64));

  assert_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid));

endmodule

bind interp8 interp8_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/interp8_tb.sv
module interp8_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_left = '0;
  logic [19:0] in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [22:0] out_left, out_right;

  always #4 clk = ~clk;

  interp8 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  int      n_chk = 0;
  int      n_err = 0;
  longint  qL[$];
  longint  qR[$];
  longint  mh1 [2][4];
  longint  mh2 [2][2];
  longint  mh3 [2][2];
  longint  mo  [2][8];
  string   tag = "R11 reset";
  bit      stall_en = 1'b0;
  int      sat_hi = 0;
  longint  last_l = 0;
  longint  last_r = 0;

  task automatic chk(bit ok, string t, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic longint rsat(longint a);
    longint r;
    r = (a + 128) >>> 8;
    if (r > 4194303) r = 4194303;
    else if (r < -4194304) r = -4194304;
    return r;
  endfunction

  function automatic void model_ch(int c, longint x);
    longint a [2];
    longint b [4];
    mh1[c][3] = mh1[c][2];
    mh1[c][2] = mh1[c][1];
    mh1[c][1] = mh1[c][0];
    mh1[c][0] = x * 8;
    a[0] = rsat(-16*mh1[c][0] + 144*mh1[c][1] + 144*mh1[c][2] - 16*mh1[c][3]);
    a[1] = rsat(256*mh1[c][1]);
    for (int i = 0; i < 2; i++) begin
      mh2[c][1] = mh2[c][0];
      mh2[c][0] = a[i];
      b[2*i]   = rsat(128*mh2[c][0] + 128*mh2[c][1]);
      b[2*i+1] = rsat(256*mh2[c][0]);
    end
    for (int i = 0; i < 4; i++) begin
      mh3[c][1] = mh3[c][0];
      mh3[c][0] = b[i];
      mo[c][2*i]   = rsat(128*mh3[c][0] + 128*mh3[c][1]);
      mo[c][2*i+1] = rsat(256*mh3[c][0]);
    end
  endfunction

  task automatic send(longint l, longint r);
    int cyc;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    chk(qL.size() == 0, "R2 previous frame delivered before accept", qL.size(), 0);
    in_valid = 1'b1;
    in_left  = l[19:0];
    in_right = r[19:0];
    model_ch(0, l);
    model_ch(1, r);
    for (int i = 0; i < 8; i++) begin
      qL.push_back(mo[0][i]);
      qR.push_back(mo[1][i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (!stall_en) begin
      cyc = 1;
      while (!in_ready && cyc < 200) begin
        @(negedge clk);
        cyc++;
      end
      chk(cyc <= 64, "R10 frame length with out_ready high", cyc, 64);
    end
  endtask

  // Output side: drive out_ready, then observe what the next edge transfers.
  initial begin
    bit     holding;
    longint hl, hr, al, ar, el, er;
    holding = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      al = longint'($signed(out_left));
      ar = longint'($signed(out_right));
      if (holding) begin
        chk(out_valid && al == hl && ar == hr, "R3 held output under stall", al, hl);
        holding = 1'b0;
      end
      if (out_valid) chk(!in_ready, "R1 in_ready low while output pending", longint'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (qL.size() == 0) begin
          chk(1'b0, "R2 unexpected extra output", al, 0);
        end else begin
          el = qL.pop_front();
          er = qR.pop_front();
          chk(al == el, {tag, " left"}, al, el);
          chk(ar == er, {tag, " right"}, ar, er);
          if (al == 4194303 || ar == 4194303) sat_hi++;
          last_l = al;
          last_r = ar;
        end
      end else if (out_valid) begin
        holding = 1'b1;
        hl = al;
        hr = ar;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    longint m;
    void'($urandom(32'd20417));
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 4; i++) mh1[c][i] = 0;
      for (int i = 0; i < 2; i++) begin
        mh2[c][i] = 0;
        mh3[c][i] = 0;
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 in_ready after reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", longint'(out_valid), 0);

    // Unit impulse on left only: rounding of tiny values, no crosstalk.
    tag = "R4 R5 R6 R7 R9 R11 unit impulse left";
    send(1, 0);
    for (int i = 0; i < 4; i++) send(0, 0);

    // Opposite impulses per channel.
    tag = "R9 opposite impulses";
    send(262144, -262144);
    for (int i = 0; i < 4; i++) send(0, 0);
    send(0, 77777);
    for (int i = 0; i < 4; i++) send(0, 0);

    // Constant level.
    tag = "R12 constant";
    for (int i = 0; i < 6; i++) send(1000, -3);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    chk(last_l == 8000, "R12 settled left equals 8x input", last_l, 8000);
    chk(last_r == -24, "R12 settled right equals 8x input", last_r, -24);

    // Full-scale steps: stage-1 overshoot reaches the clamp.
    tag = "R8 full-scale step";
    m = 524287;
    for (int i = 0; i < 4; i++) send(-m - 1, -m - 1);
    for (int i = 0; i < 5; i++) send(m, m);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    chk(sat_hi > 0, "R8 positive clamp reached", sat_hi, 1);

    // Full-scale sine.
    tag = "R4 R5 R6 full-scale sine";
    for (int i = 0; i < 24; i++) begin
      m = longint'($rtoi(524287.0 * $sin(6.283185307 * i / 11.0)));
      send(m, -m);
    end

    // Random pairs with random output stalls.
    tag = "R3 R7 random stalled";
    stall_en = 1'b1;
    for (int i = 0; i < 120; i++) begin
      send(longint'($urandom_range(0, 1048575)) - 524288,
           longint'($urandom_range(0, 1048575)) - 524288);
    end
    while (qL.size() != 0) @(negedge clk);
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1 idle after last frame", longint'(in_ready), 1);
    chk(qL.size() == 0, "R2 all outputs delivered", qL.size(), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule